// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output cell of a small sum-of-products programmable logic device. The cell takes the OR-plane result for its pin (`sop_term`) and a per-pin enable term (`oe_term`). It also takes a clear term and a set term that every cell in the device shares. A two-bit static configuration chooses one of two paths. In registered mode the value passes through a D flip-flop clocked by the device-wide clock. In combinational mode it goes straight to the pin. The same configuration picks the output polarity.

The cell drives a pad model through separate value, enable and pin-sense signals. It returns one feedback bit to the AND plane, and the source of that bit depends on the mode. In registered mode the array sees the true flip-flop state, before any inversion, which is what a state machine built in the array needs. In combinational mode the array sees the pin. When the enable term is low the pin is not driven, so the cell works as an input. Toggling the enable term makes the pin bidirectional.

Top module: `pal_out_cell`

## Requirements
- R1: `mode_cfg[1]` selects the path (0 = registered, 1 = combinational). `mode_cfg[0]` selects the polarity (0 = active-low, so the pin carries the inverted value; 1 = active-high).
- R2: In registered mode, with no preset and no clear, the flip-flop takes `sop_term` at each rising edge of `clk`. `pad_out` shows that state, inverted when the active-low setting is chosen.
- R3: In combinational mode, `pad_out` follows `sop_term` (inverted when active-low) within the same cycle, without waiting for a clock edge.
- R4: `pad_oe` equals `oe_term` at all times, in every mode.
- R5: In registered mode, `array_fb` is the true flip-flop state, before the polarity inversion. It does not depend on `pad_in` or `oe_term`.
- R6: In combinational mode with `oe_term` high, `array_fb` equals the driven pin value `pad_out`.
- R7: In combinational mode with `oe_term` low, `array_fb` equals `pad_in`, so the pin acts as an input.
- R8: A high `glob_clr` clears the flip-flop at once, without a clock. The flip-flop stays clear while `glob_clr` is high, and the clear wins over `glob_set`.
- R9: A high `glob_set` at a rising edge loads 1 into the flip-flop whatever the value of `sop_term`, unless `glob_clr` is high.
- R10: A high `por` clears the flip-flop asynchronously. After `por` is released the flip-flop reads 0 until a clock edge loads a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device-wide clock |
| por | input | 1 | Power-on clear, asynchronous, active high |
| mode_cfg | input | 2 | Static configuration: bit 1 selects the path, bit 0 selects the polarity |
| sop_term | input | 1 | Sum-of-products data term from the array |
| oe_term | input | 1 | Per-pin output-enable term |
| glob_clr | input | 1 | Shared asynchronous clear term |
| glob_set | input | 1 | Shared synchronous set term |
| pad_in | input | 1 | Value sensed on the pin |
| pad_out | output | 1 | Value driven toward the pin |
| pad_oe | output | 1 | Pin driver enable |
| array_fb | output | 1 | Feedback bit returned to the array |

## Verification
The vector table applies each of the four configurations with both data values. This separates the path choice from the polarity choice, and it exposes a swapped or dropped inversion. In registered rows the bench drives a pin value that differs from the flip-flop state, which shows whether feedback comes from the true state rather than from the pin or the inverted output. In combinational rows it toggles the enable term while an external value that disagrees with `pad_out` sits on the pin, so driven-pin feedback and input-pin feedback give different answers. Directed sequences raise the clear and set terms together and mid-cycle, to tell asynchronous clearing, clear-over-set priority and the set term's edge timing apart.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;
  localparam int CFG_W = 2;

  typedef struct packed {
    logic comb;      // 1: combinational path, 0: registered path
    logic act_high;  // 1: true polarity at the pin, 0: inverted
  } cell_cfg_t;

  function automatic cell_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    cell_cfg_t c;
    c.comb     = raw[1];
    c.act_high = raw[0];
    return c;
  endfunction

  function automatic logic apply_polarity(input logic v, input logic act_high);
    return act_high ? v : ~v;
  endfunction

  function automatic logic next_state(input logic d, input logic set_term);
    return set_term ? 1'b1 : d;
  endfunction
endpackage

// File: rtl/pal_cell_reg.sv
module pal_cell_reg (
  input  logic clk,
  input  logic por,
  input  logic clr_term,
  input  logic set_term,
  input  logic d,
  output logic q
);
  import pal_cell_pkg::*;

  logic clear_any;
  logic d_next;
  assign clear_any = por | clr_term;
  assign d_next    = next_state(d, set_term);

  always_ff @(posedge clk or posedge clear_any) begin
    if (clear_any) q <= 1'b0;
    else           q <= d_next;
  end

  p_clr_holds_r8: assert property (@(posedge clk) disable iff (por)
    clr_term |-> (q == 1'b0));

  p_set_loads_r9: assert property (@(posedge clk) disable iff (clear_any)
    set_term |=> q);

  p_data_loads_r2: assert property (@(posedge clk) disable iff (clear_any)
    !set_term |=> (q == $past(d)));
endmodule

// File: rtl/pal_cell_drive.sv
module pal_cell_drive
  import pal_cell_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      q,
  input  logic      sop,
  input  logic      oe,
  output logic      pad_out,
  output logic      pad_oe
);
  logic core_val;
  assign core_val = cfg.comb ? sop : q;
  assign pad_out  = apply_polarity(core_val, cfg.act_high);
  assign pad_oe   = oe;
endmodule

// File: rtl/pal_cell_fb.sv
module pal_cell_fb
  import pal_cell_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      q,
  input  logic      pad_oe,
  input  logic      pad_out,
  input  logic      pad_in,
  output logic      fb
);
  logic pin_val;
  assign pin_val = pad_oe ? pad_out : pad_in;
  assign fb      = cfg.comb ? pin_val : q;
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell (
  input  logic       clk,
  input  logic       por,
  input  logic [1:0] mode_cfg,
  input  logic       sop_term,
  input  logic       oe_term,
  input  logic       glob_clr,
  input  logic       glob_set,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       array_fb
);
  import pal_cell_pkg::*;

  cell_cfg_t cfg;
  logic      state_q;
  assign cfg = decode_cfg(mode_cfg);

  pal_cell_reg u_reg (
    .clk      (clk),
    .por      (por),
    .clr_term (glob_clr),
    .set_term (glob_set),
    .d        (sop_term),
    .q        (state_q)
  );

  pal_cell_drive u_drive (
    .cfg     (cfg),
    .q       (state_q),
    .sop     (sop_term),
    .oe      (oe_term),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  pal_cell_fb u_fb (
    .cfg     (cfg),
    .q       (state_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_in  (pad_in),
    .fb      (array_fb)
  );

  // R5 and R1: registered feedback is the true state; the pin shows it with the chosen polarity
  p_reg_fb_true_r5: assert property (@(posedge clk) disable iff (por)
    !mode_cfg[1] |-> (mode_cfg[0] ? (pad_out == array_fb) : (pad_out != array_fb)));

  p_comb_driven_fb_r6: assert property (@(posedge clk) disable iff (por)
    (mode_cfg[1] && oe_term) |-> (array_fb == pad_out));

  p_comb_input_fb_r7: assert property (@(posedge clk) disable iff (por)
    (mode_cfg[1] && !oe_term) |-> (array_fb == pad_in));

  p_comb_path_r3: assert property (@(posedge clk) disable iff (por)
    mode_cfg[1] |-> ((pad_out ^ sop_term) == !mode_cfg[0]));
endmodule

// File: tb/test_pal_out_cell.sv
module test_pal_out_cell;
  logic       clk = 1'b0;
  logic       por, oe_term, sop_term, glob_clr, glob_set, ext_drive;
  logic [1:0] mode_cfg;
  logic       pad_out, pad_oe, array_fb, pad_in;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  // pad model: the pin carries the driver when enabled, else an external source
  assign pad_in = pad_oe ? pad_out : ext_drive;

  pal_out_cell i_pal_out_cell (
    .clk(clk), .por(por), .mode_cfg(mode_cfg), .sop_term(sop_term),
    .oe_term(oe_term), .glob_clr(glob_clr), .glob_set(glob_set),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .array_fb(array_fb)
  );

  typedef struct packed {
    logic [1:0] cfg;
    logic sop, oe, ext, set;
    logic e_out, e_oe, e_fb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R2 R1 reg high
    '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 pin ignored
    '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 fb before inversion
    '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 set, low
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R9 set, high
    '{2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 R6
    '{2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R6
    '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 inverted
    '{2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 input
    '{2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 input
    '{2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}   // R7 with set
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por = 1'b1; mode_cfg = 2'b01; sop_term = 1'b1; oe_term = 1'b1;
    glob_clr = 1'b0; glob_set = 1'b0; ext_drive = 1'b0;
    tick(); tick();
    check("R10", "reset pad_out high-active", pad_out, 1'b0);
    check("R10", "reset fb", array_fb, 1'b0);
    mode_cfg = 2'b00; #1;
    check("R10", "reset pad_out low-active", pad_out, 1'b1);
    sop_term = 1'b0; por = 1'b0; mode_cfg = 2'b01; #1;
    check("R10", "after release", pad_out, 1'b0);
    tick();

    // vector table
    for (int i = 0; i < NV; i++) begin
      mode_cfg = VEC[i].cfg; sop_term = VEC[i].sop; oe_term = VEC[i].oe;
      ext_drive = VEC[i].ext; glob_set = VEC[i].set;
      tick();
      check("R1", $sformatf("vec %0d pad_out", i), pad_out, VEC[i].e_out);
      check("R4", $sformatf("vec %0d pad_oe", i), pad_oe, VEC[i].e_oe);
      check("R5", $sformatf("vec %0d array_fb", i), array_fb, VEC[i].e_fb);
    end
    glob_set = 1'b0;

    // R3: combinational change without a clock edge
    mode_cfg = 2'b11; oe_term = 1'b1; sop_term = 1'b0; #1;
    sop_term = 1'b1; #1;
    check("R3", "comb no-edge high", pad_out, 1'b1);
    mode_cfg = 2'b10; #1;
    check("R3", "comb no-edge low", pad_out, 1'b0);

    // R4: enable follows mid-cycle
    oe_term = 1'b0; #1;
    check("R4", "oe low", pad_oe, 1'b0);
    oe_term = 1'b1; #1;
    check("R4", "oe high", pad_oe, 1'b1);

    // R8: asynchronous clear and priority over set
    tick();
    mode_cfg = 2'b01; sop_term = 1'b1; glob_set = 1'b0;
    tick();
    check("R2", "load 1", pad_out, 1'b1);
    #1 glob_clr = 1'b1; #1;
    check("R8", "async clear", pad_out, 1'b0);
    glob_set = 1'b1;
    tick();
    check("R8", "clear over set", array_fb, 1'b0);
    glob_clr = 1'b0; glob_set = 1'b0; sop_term = 1'b0;
    tick();
    check("R8", "after clear", pad_out, 1'b0);
    glob_set = 1'b1;
    tick();
    check("R9", "set over data 0", pad_out, 1'b1);
    glob_set = 1'b0;

    // R10: power-on clear mid-run
    #1 por = 1'b1; #1;
    check("R10", "por async clear", array_fb, 1'b0);
    tick(); por = 1'b0; sop_term = 1'b1;
    tick();
    check("R2", "load after por", array_fb, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule